// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is the general-purpose register store of a processor core that issues one instruction per clock. It keeps 32 registers of 32 bits. Two operand indices are looked up at the same time, and one result is written back in the same cycle. Both read ports are purely combinational: the data follows the index with no clock involved. The single write port commits on the rising clock edge, and only while its enable is high.

Register zero is a constant. It has no storage, it always reads as zero, and writes aimed at it are dropped. A synchronous reset clears every register. If a write arrives on the same edge as the reset, the reset wins.

There is no bypass from the write port to the read ports. A value being written appears on a read port only after the edge that stores it.

Top module: `dualport_regbank`

## Requirements
- R1: The block holds NUM_REGS (default 32) registers of DATA_W (default 32) bits, each selected by an index of clog2(NUM_REGS) bits, and every register from 1 to 31 can be written and read back independently.
- R2: Both read ports and the write port act in the same cycle and do not interfere. Both read ports may select the same register, including the one being written, and each returns the stored value.
- R3: When wrEn is 1 at a rising edge and wrIdx is not 0, register wrIdx takes wrData. A read port selecting that register shows the new value after that edge.
- R4: When wrEn is 0 at a rising edge, no register changes, whatever wrIdx and wrData hold.
- R5: Each read data output follows its read index combinationally, with no clock edge needed.
- R6: A read port whose index is 0 outputs zero at all times.
- R7: A write with wrIdx equal to 0 changes no register, and register 0 still reads zero.
- R8: When rst is 1 at a rising edge, every register reads zero afterwards.
- R9: When rst and wrEn are both 1 at the same edge, the write is discarded and the target register reads zero.
- R10: A write does not show on a read port before the edge that commits it; until that edge the port shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| rdIdxA | input | IDX_W | Register index for read port A |
| rdDataA | output | DATA_W | Contents of register rdIdxA |
| rdIdxB | input | IDX_W | Register index for read port B |
| rdDataB | output | DATA_W | Contents of register rdIdxB |
| wrEn | input | 1 | Write enable, active high |
| wrIdx | input | IDX_W | Destination register index |
| wrData | input | DATA_W | Data to be written |

## Verification
A register holding a wrong value shows at the ports as soon as a read index selects it, in the same cycle with no clock needed. The sweeps therefore read every index through both ports after each kind of event: a write, a disabled write, a write to index 0, and a reset. Any corrupted row, or a write that lands in the wrong row, is found at the first sweep after it happens. Timing faults, where a write shows too early or too late, are caught by sampling the selected port both just before and just after the committing edge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Strobes from the write control to the storage datapath
  typedef struct packed {
    logic clearAll;  // synchronous clear of every stored row
    logic commit;    // store wrData into the selected row
  } bankCtl_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5
) (
  input  logic                rst,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  output bankCtl_t            ctl,
  output logic [NUM_REGS-1:0] rowSel
);

  logic idxIsZero;

  assign idxIsZero = (wrIdx == '0);

  // Reset has priority; a write aimed at index 0 is dropped here
  always_comb begin
    ctl.clearAll = rst;
    ctl.commit   = wrEn && !rst && !idxIsZero;
  end

  // One-hot row decode
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    assign rowSel[r] = (wrIdx == IDX_W'(r));
  end

endmodule

// File: rtl/regbank_readmux.sv
module regbank_readmux #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5
) (
  input  logic [DATA_W-1:0] rows [NUM_REGS],
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] data
);

  // Index 0 is forced to zero by decode, not by the stored row
  always_comb begin
    if (idx == '0) begin
      data = '0;
    end else begin
      data = rows[idx];
    end
  end

endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  bankCtl_t            ctl,
  input  logic [NUM_REGS-1:0] rowSel,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rows [NUM_REGS]
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    if (r == 0) begin : g_zero
      assign rows[r] = '0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (ctl.clearAll) begin
          rows[r] <= '0;
        end else if (ctl.commit && rowSel[r]) begin
          rows[r] <= wrData;
        end
      end
    end
  end

endmodule

// File: rtl/dualport_regbank.sv
module dualport_regbank
  import regbank_pkg::*;
#(
  parameter int  NUM_REGS = 32,
  parameter int  DATA_W   = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData
);

  bankCtl_t            ctl;
  logic [NUM_REGS-1:0] rowSel;
  logic [DATA_W-1:0]   rows [NUM_REGS];

  regbank_ctrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .ctl(ctl), .rowSel(rowSel)
  );

  regbank_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .ctl(ctl), .rowSel(rowSel), .wrData(wrData), .rows(rows)
  );

  regbank_readmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdA (
    .rows(rows), .idx(rdIdxA), .data(rdDataA)
  );

  regbank_readmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdB (
    .rows(rows), .idx(rdIdxB), .data(rdDataB)
  );

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [IDX_W-1:0]  rdIdxB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [DATA_W-1:0] wrData
);

  assert_zero_read_a_R6: assert property (@(posedge clk) disable iff (rst)
    (rdIdxA == '0) |-> (rdDataA == '0));

  assert_zero_read_b_R6: assert property (@(posedge clk) disable iff (rst)
    (rdIdxB == '0) |-> (rdDataB == '0));

  assert_write_lands_a_R3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx != '0) |=> (rdIdxA != $past(wrIdx) || rdDataA == $past(wrData)));

  assert_write_lands_b_R3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrIdx != '0) |=> (rdIdxB != $past(wrIdx) || rdDataB == $past(wrData)));

  assert_untouched_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!wrEn || wrIdx != rdIdxA) |=> (rdIdxA != $past(rdIdxA) || rdDataA == $past(rdDataA)));

endmodule

bind dualport_regbank regbank_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB),
  .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
);

// File: tb/dualport_regbank_test.sv
`timescale 1ns/1ps
module dualport_regbank_test;

  localparam int N  = 32;
  localparam int DW = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst;
  logic [IW-1:0] rdIdxA, rdIdxB, wrIdx;
  logic [DW-1:0] rdDataA, rdDataB, wrData;
  logic wrEn;

  logic [DW-1:0] model [N];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dualport_regbank uut (
    .clk(clk), .rst(rst), .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB),
    .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );

  function automatic logic [DW-1:0] pat(int i, int s);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'(s), ~b, 8'(i * 37 + s), 8'h5A ^ 8'(s * 3)};
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Read every index through both ports (B walks backwards)
  task automatic sweep(string req);
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      rdIdxA = IW'(a);
      rdIdxB = IW'(N - 1 - a);
      #1;
      check(req, rdDataA, model[a]);
      check(req, rdDataB, model[N - 1 - a]);
    end
  endtask

  // One write cycle with port A watching the target
  task automatic doWrite(logic en, int idx, logic [DW-1:0] d, string reqPre, string reqPost);
    @(negedge clk);
    wrEn = en; wrIdx = IW'(idx); wrData = d; rdIdxA = IW'(idx);
    #1;
    check(reqPre, rdDataA, model[idx]);
    @(posedge clk);
    if (en && idx != 0) model[idx] = d;
    #1;
    check(reqPost, rdDataA, model[idx]);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; wrIdx = '0; wrData = '0; rdIdxA = '0; rdIdxB = '0;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R8: reset state
    sweep("R8 reset state");

    // R1 R3 R10: fill every register, watch the edge
    for (int i = 0; i < N; i++) doWrite(1'b1, i, pat(i, 1), "R10 before edge", "R3 after edge");
    // R1 R2 R5 R6 R7: read back all, both ports
    sweep("R1 readback");

    // R5: combinational index change without a clock edge
    @(negedge clk);
    rdIdxA = 5'd3; #1; check("R5 comb read", rdDataA, model[3]);
    rdIdxA = 5'd30; #1; check("R5 comb read", rdDataA, model[30]);
    rdIdxA = 5'd0; #1; check("R6 zero read", rdDataA, '0);

    // R4: disabled write has no effect
    doWrite(1'b0, 7, 32'hDEAD_BEEF, "R4 before", "R4 disabled write");
    sweep("R4 nothing changed");

    // R2: both ports on the register being written
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'd9; wrData = pat(9, 7); rdIdxA = 5'd9; rdIdxB = 5'd9;
    #1;
    check("R2 A before", rdDataA, model[9]);
    check("R2 B before", rdDataB, model[9]);
    @(posedge clk); model[9] = pat(9, 7); #1;
    check("R2 A after", rdDataA, model[9]);
    check("R2 B after", rdDataB, model[9]);
    @(negedge clk); wrEn = 1'b0;

    // R7: write to index 0 is dropped
    doWrite(1'b1, 0, 32'hFFFF_FFFF, "R7 before", "R7 zero write");
    sweep("R7 no row changed");

    // Second data pattern across all rows
    for (int i = 1; i < N; i++) doWrite(1'b1, i, pat(i, 200), "R10 before edge", "R3 after edge");
    sweep("R1 second pattern");

    // R9: reset with a simultaneous write
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; wrIdx = 5'd5; wrData = 32'h1234_5678; rdIdxA = 5'd5;
    @(posedge clk);
    for (int i = 0; i < N; i++) model[i] = '0;
    #1;
    check("R9 reset beats write", rdDataA, '0);
    @(negedge clk); rst = 1'b0; wrEn = 1'b0;
    sweep("R8 cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule